// File: doc/BRIEF.md
# Maskable Interrupt Request Hub

This block gathers seven hardware event sources into a sticky request register, gates them through an enable register, and drives one interrupt pin whose active level can be flipped. The sources are, from bit 6 down to bit 0: card detect, timer, transmit done, receive done, idle, FIFO high alert and FIFO low alert. Logic elsewhere in the chip raises each event as a one-cycle pulse on `evt_set`.

The host changes both registers through one write port. The top data bit is a mode flag. Only the bits written as 1 are affected, and all other bits keep their value. For the enable register the flag picks between set and clear. For the request register only clear exists: the host can clear requests but never raise them. A status bit reports whether any request is pending, whatever the enables hold.

All outputs are registered. After a write or an event, the new register contents, the status bit and the pin all appear together one clock edge later.

Top module: `irq_hub`

## Requirements
- R1: On synchronous reset, `en_q` is 0x00, `req_q` is 0x05 (idle at bit 2 and FIFO low alert at bit 0 pending), `any_req` is 1 and `irq_pin` equals `pin_invert`.
- R2: A write with `wr_sel`=0 and `wr_data[7]`=1 sets every enable bit whose `wr_data` bit is 1. The remaining enable bits do not change, so 0xFF enables all seven sources.
- R3: A write with `wr_sel`=0 and `wr_data[7]`=0 clears every enable bit whose `wr_data` bit is 1. The remaining enable bits do not change, so 0x7F disables all sources.
- R4: A write with `wr_sel`=1 and `wr_data[7]`=0 clears every request bit whose `wr_data` bit is 1. The remaining request bits do not change.
- R5: A write with `wr_sel`=1 and `wr_data[7]`=1 leaves `req_q` unchanged.
- R6: A 1 on `evt_set[i]` sets `req_q[i]` at the next edge, whatever the enables hold. The bit order from 6 down to 0 is card detect, timer, transmit, receive, idle, FIFO high, FIFO low.
- R7: When a hardware event and a host clear hit the same request bit in the same cycle, the bit ends up set.
- R8: `any_req` is 1 exactly when at least one bit of `req_q` is 1.
- R9: `irq_pin` equals `pin_invert` (as sampled at the same edge) XOR the OR of (`req_q` AND `en_q`).
- R10: Bit 7 of `en_q` and of `req_q` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Register select: 0 enable, 1 request |
| wr_data | input | 8 | Bit 7 is the mode flag, bits 6..0 are the bit mask |
| evt_set | input | 7 | Hardware event pulses, one per source |
| pin_invert | input | 1 | 1 makes the interrupt pin active low |
| en_q | output | 8 | Enable register readback |
| req_q | output | 8 | Request register readback |
| any_req | output | 1 | High while any request is pending |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The bench targets the masked nature of the writes. It sets and clears single bits next to bits that are already set, and checks that the untouched bits survive. A design that loaded the whole value would wipe the neighbours. It writes a request with the mode flag high, which must be ignored. A design that treated that write as a set would raise a request the host cannot create. It drives an event and a host clear at the same bit in one cycle. A design with the wrong priority would lose the interrupt. It also moves the polarity input while a request is active, and it applies reset mid-run with inversion on, where a pin reset to a fixed 0 would show up as wrong.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned SRC_N = 7;

  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_REQUEST = 1'b1
  } reg_sel_e;

  localparam int unsigned B_CARD   = 6;
  localparam int unsigned B_TIMER  = 5;
  localparam int unsigned B_TX     = 4;
  localparam int unsigned B_RX     = 3;
  localparam int unsigned B_IDLE   = 2;
  localparam int unsigned B_FIFOHI = 1;
  localparam int unsigned B_FIFOLO = 0;

  localparam logic [SRC_N-1:0] REQ_RESET = 7'((1 << B_IDLE) | (1 << B_FIFOLO));
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned  W         = 7,
  parameter bit           ALLOW_SET = 1'b1,
  parameter logic [W-1:0] RST_VAL   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W:0]   wdat,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic         mode_set;
  logic [W-1:0] mask;
  logic [W-1:0] host_set;
  logic [W-1:0] host_clr;

  assign mode_set = wdat[W];
  assign mask     = wdat[W-1:0];
  assign host_clr = (wr && !mode_set) ? mask : '0;

  generate
    if (ALLOW_SET) begin : g_set
      assign host_set = (wr && mode_set) ? mask : '0;
    end else begin : g_noset
      assign host_set = '0;
    end
  endgenerate

  // Hardware and host sets take priority over host clears.
  assign q_next = (q & ~host_clr) | host_set | hw_set;

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= q_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr && hw_set == '0) |=> $stable(q)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set))); // R7
  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdat[W] && hw_set == '0) |=> ((q & $past(wdat[W-1:0])) == '0)); // R3
  generate
    if (!ALLOW_SET) begin : g_chk_noset
      AST_NO_HOST_SET: assert property (@(posedge clk) disable iff (rst)
        (wr && wdat[W] && hw_set == '0) |=> $stable(q)); // R5
    end
  endgenerate
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_next,
  input  logic [W-1:0] en_next,
  input  logic         invert,
  output logic         any_q,
  output logic         pin_q
);
  logic active;
  assign active = |(req_next & en_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q <= |irq_hub_pkg::REQ_RESET;
      pin_q <= invert;
    end else begin
      any_q <= |req_next;
      pin_q <= active ^ invert;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned SRC_N = irq_hub_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [SRC_N:0]   wr_data,
  input  logic [SRC_N-1:0] evt_set,
  input  logic             pin_invert,
  output logic [SRC_N:0]   en_q,
  output logic [SRC_N:0]   req_q,
  output logic             any_req,
  output logic             irq_pin
);
  import irq_hub_pkg::*;

  logic             wr_en_reg;
  logic             wr_req_reg;
  logic [SRC_N-1:0] en_r, en_n;
  logic [SRC_N-1:0] req_r, req_n;

  assign wr_en_reg  = wr_en && (wr_sel == SEL_ENABLE);
  assign wr_req_reg = wr_en && (wr_sel == SEL_REQUEST);

  irq_mask_reg #(.W(SRC_N), .ALLOW_SET(1'b1), .RST_VAL('0)) u_en (
    .clk(clk), .rst(rst), .wr(wr_en_reg), .wdat(wr_data),
    .hw_set('0), .q(en_r), .q_next(en_n)
  );

  irq_mask_reg #(.W(SRC_N), .ALLOW_SET(1'b0), .RST_VAL(SRC_N'(REQ_RESET))) u_req (
    .clk(clk), .rst(rst), .wr(wr_req_reg), .wdat(wr_data),
    .hw_set(evt_set), .q(req_r), .q_next(req_n)
  );

  irq_pin_drv #(.W(SRC_N)) u_pin (
    .clk(clk), .rst(rst), .req_next(req_n), .en_next(en_n),
    .invert(pin_invert), .any_q(any_req), .pin_q(irq_pin)
  );

  assign en_q  = {1'b0, en_r};
  assign req_q = {1'b0, req_r};

  AST_STATUS_ANY: assert property (@(posedge clk) disable iff (rst)
    any_req == (req_q != '0)); // R8
  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_pin == ($past(pin_invert) ^ (|(req_q & en_q)))); // R9
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((req_q[SRC_N-1:0] & $past(evt_set)) == $past(evt_set))); // R6
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  typedef struct packed {
    logic       wen;
    logic       sel;
    logic [7:0] dat;
    logic [6:0] evt;
    logic       inv;
    logic [7:0] x_en;
    logic [7:0] x_req;
    logic       x_any;
    logic       x_irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 8'h83, 7'h00, 1'b0, 8'h03, 8'h05, 1'b1, 1'b1}, // R2 set bits 0,1
    '{1'b1, 1'b0, 8'h01, 7'h00, 1'b0, 8'h02, 8'h05, 1'b1, 1'b0}, // R3 clear bit 0 only
    '{1'b1, 1'b1, 8'h81, 7'h00, 1'b0, 8'h02, 8'h05, 1'b1, 1'b0}, // R5 ignored
    '{1'b1, 1'b1, 8'h05, 7'h00, 1'b0, 8'h02, 8'h00, 1'b0, 1'b0}, // R4 clear requests
    '{1'b0, 1'b0, 8'h00, 7'h40, 1'b0, 8'h02, 8'h40, 1'b1, 1'b0}, // R6 card detect, masked
    '{1'b1, 1'b0, 8'hFF, 7'h00, 1'b0, 8'h7F, 8'h40, 1'b1, 1'b1}, // R2 all enables, R10
    '{1'b0, 1'b0, 8'h00, 7'h00, 1'b1, 8'h7F, 8'h40, 1'b1, 1'b0}, // R9 inverted
    '{1'b1, 1'b1, 8'h40, 7'h40, 1'b0, 8'h7F, 8'h40, 1'b1, 1'b1}, // R7 set wins
    '{1'b1, 1'b0, 8'h7F, 7'h00, 1'b0, 8'h00, 8'h40, 1'b1, 1'b0}, // R3 all disabled
    '{1'b1, 1'b1, 8'h7F, 7'h02, 1'b0, 8'h00, 8'h02, 1'b1, 1'b0}, // R7 other bit set
    '{1'b1, 1'b1, 8'h02, 7'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}, // R8 none pending
    '{1'b1, 1'b0, 8'h84, 7'h04, 1'b1, 8'h04, 8'h04, 1'b1, 1'b0}, // R9 active, inverted
    '{1'b0, 1'b0, 8'h00, 7'h00, 1'b0, 8'h04, 8'h04, 1'b1, 1'b1}  // R9 active, normal
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 5:     return "R2";
      1, 8:     return "R3";
      2:        return "R5";
      3:        return "R4";
      4:        return "R6";
      6, 11, 12: return "R9";
      7, 9:     return "R7";
      default:  return "R8";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, wr_sel, pin_invert;
  logic [7:0] wr_data;
  logic [6:0] evt_set;
  logic [7:0] en_q, req_q;
  logic       any_req, irq_pin;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_set(evt_set), .pin_invert(pin_invert), .en_q(en_q), .req_q(req_q),
    .any_req(any_req), .irq_pin(irq_pin)
  );

  task automatic check(input string tag, input logic [7:0] e_en, input logic [7:0] e_req,
                       input logic e_any, input logic e_irq);
    n_chk++;
    if (en_q !== e_en || req_q !== e_req || any_req !== e_any || irq_pin !== e_irq) begin
      n_fail++;
      $display("FAIL %s: en=%h req=%h any=%b irq=%b expected en=%h req=%h any=%b irq=%b",
               tag, en_q, req_q, any_req, irq_pin, e_en, e_req, e_any, e_irq);
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; evt_set = '0; pin_invert = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 8'h00, 8'h05, 1'b1, 1'b0);
    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wen; wr_sel = VEC[i].sel; wr_data = VEC[i].dat;
      evt_set = VEC[i].evt; pin_invert = VEC[i].inv;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; evt_set = '0;
      check(tag_of(i), VEC[i].x_en, VEC[i].x_req, VEC[i].x_any, VEC[i].x_irq);
    end
    // R10: mode bit never stored
    n_chk++;
    if (en_q[7] !== 1'b0 || req_q[7] !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: en7=%b req7=%b expected 0 0", en_q[7], req_q[7]);
    end
    // R1: reset mid-run with inversion on
    pin_invert = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 8'h00, 8'h05, 1'b1, 1'b1);
    // R6: every source lands in its own bit
    for (int b = 0; b < 7; b++) begin
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h7F; pin_invert = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; evt_set = 7'(1 << b);
      @(posedge clk);
      @(negedge clk);
      evt_set = '0;
      check("R6", 8'h00, 8'(1 << b), 1'b1, 1'b0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule